// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of an 8K-byte serial memory that is reached over a two-wire (I2C-style) bus. A fast system clock samples the SCL and SDA lines. The engine finds start and stop conditions and takes in the select byte and a two-byte word address. It answers each accepted byte by pulling SDA low, and it shifts read data back to the master. A word pointer carries over from one transaction to the next. This supports reads at the current address, random reads (a write-mode select plus address, then a repeated start and a read-mode select) and sequential reads that run past the top of the array and back to zero.

Each written data byte is passed out with its address as a one-cycle strobe. A stop that follows at least one data byte raises a commit pulse. A separate page-programming block buffers these bytes and runs the internal write cycle. While that cycle runs it holds a busy input high, and the engine then stays silent. A small synchronous RAM model stands in for the cell array. It is written by the same byte strobe and feeds the read path.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) aborts any transfer in progress, including one cut off mid-byte, and the next select byte is decoded afresh. A stop (SDA rising while SCL is high) releases SDA and returns the engine to idle.
- R2: A select byte is taken MSB first. It is accepted only when its upper four bits are 1010 and the next three match the strap inputs. A rejected select is not acknowledged, and no later byte is acknowledged until the next start.
- R3: After a write-mode select (bit 0 = 0), two address bytes follow. The pointer is loaded from the low 13 bits and the top 3 bits of the first byte are ignored. Every following data byte is acknowledged and appears as a one-cycle strobe with its address and data.
- R4: During a write, the pointer steps by one within a 32-byte page. The low 5 bits wrap from 31 to 0 and the upper 8 bits stay fixed.
- R5: A stop after one or more data bytes gives exactly one commit pulse. A stop after an address with no data gives none. A start that cuts a write short gives none.
- R6: A random read (write select, address, repeated start, read select with bit 0 = 1) returns the byte at the newly loaded address.
- R7: In a read, each master acknowledge makes the next byte come from the address one higher. The pointer wraps from 8191 to 0.
- R8: A read select with no address starts at the pointer left by the last transfer, which is one past the last byte read.
- R9: While the busy input is high, a matching select byte is not acknowledged.
- R10: The SDA pull changes only while synchronized SCL is low. The slave releases SDA during the master's acknowledge bit after each read byte.
- R11: After reset, SDA is released and neither the byte strobe nor the commit pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| strap_i | input | 3 | Device strap bits compared with select bits 3..1 |
| prog_busy_i | input | 1 | High while the internal write cycle runs |
| sda_pull_o | output | 1 | Drive-low enable for the open-drain SDA pad |
| wbyte_valid_o | output | 1 | One-cycle strobe per received data byte |
| wbyte_addr_o | output | 13 | Array address of the strobed byte |
| wbyte_data_o | output | 8 | Strobed data byte |
| wcommit_o | output | 1 | One-cycle pulse on a stop that ends a write with data |

## Verification
A pointer that goes wrong shows up as the wrong byte at the first read after it: the next read bit, or the address on the next write strobe. Page wrap, whole-array wrap and current-address continuation each have a check on the byte right after the boundary. A wrong protocol state shows up within one byte time as a missing or extra acknowledge in the ninth clock. The bench samples that bit for every byte it sends, including those that must stay unanswered after a bad select, while busy, and after a start that cuts a byte short. A bad pending-write flag shows up only on the commit pulse at the stop, so each stop in the bench is followed by a count of commit pulses.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_MACK
  } tw_state_e;
endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_prev;
  logic                   sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_raw};
      scl_prev <= scl_pipe[SYNC_STAGES-1];
      sda_prev <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/tw_array_model.sv
module tw_array_model #(
  parameter int ADDR_W   = 13,
  parameter int MODEL_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << MODEL_AW;

  logic [7:0]          mem [DEPTH];
  logic [MODEL_AW-1:0] widx;
  logic [MODEL_AW-1:0] ridx;

  generate
    if (MODEL_AW >= ADDR_W) begin : g_direct
      assign widx = MODEL_AW'(waddr);
      assign ridx = MODEL_AW'(raddr);
    end else begin : g_fold
      assign widx = waddr[MODEL_AW-1:0] + MODEL_AW'(waddr[ADDR_W-1:MODEL_AW]);
      assign ridx = raddr[MODEL_AW-1:0] + MODEL_AW'(raddr[ADDR_W-1:MODEL_AW]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm
  import tw_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic              prog_busy,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] ptr,
  output logic              wbyte_valid,
  output logic [ADDR_W-1:0] wbyte_addr,
  output logic [7:0]        wbyte_data,
  output logic              wcommit
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  tw_state_e         state_q, state_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic              in_ack_q, in_ack_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [7:0]        tx_q, tx_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              pull_q, pull_d;
  logic              pend_q, pend_d;
  logic              mack_q, mack_d;
  logic              rw_q, rw_d;
  logic              wv_q, wv_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [7:0]        wd_q, wd_d;
  logic              commit_q, commit_d;

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    in_ack_d = in_ack_q;
    shreg_d  = shreg_q;
    tx_d     = tx_q;
    ptr_d    = ptr_q;
    pull_d   = pull_q;
    pend_d   = pend_q;
    mack_d   = mack_q;
    rw_d     = rw_q;
    wv_d     = 1'b0;
    wa_d     = wa_q;
    wd_d     = wd_q;
    commit_d = 1'b0;

    if (start_det) begin
      state_d  = ST_DEV;
      bitcnt_d = '0;
      in_ack_d = 1'b0;
      pull_d   = 1'b0;
      pend_d   = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      in_ack_d = 1'b0;
      pull_d   = 1'b0;
      commit_d = pend_q;
      pend_d   = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !in_ack_q && bitcnt_q < BYTE_BITS) begin
            shreg_d  = {shreg_q[6:0], sda_lvl};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && in_ack_q) begin
            // end of the ninth clock: release and move on
            in_ack_d = 1'b0;
            bitcnt_d = '0;
            pull_d   = 1'b0;
            case (state_q)
              ST_DEV: begin
                if (rw_q) begin
                  state_d = ST_RDAT;
                  tx_d    = rd_data;
                  pull_d  = ~rd_data[7];
                end else begin
                  state_d = ST_AHI;
                end
              end
              ST_AHI:  state_d = ST_ALO;
              default: state_d = ST_WDAT;
            endcase
          end else if (scl_fall && bitcnt_q == BYTE_BITS) begin
            // byte complete: decide on the acknowledge
            case (state_q)
              ST_DEV: begin
                if (shreg_q[7:1] == {DEV_CODE, strap} && !prog_busy) begin
                  in_ack_d = 1'b1;
                  pull_d   = 1'b1;
                  rw_d     = shreg_q[0];
                end else begin
                  state_d = ST_IDLE;
                end
              end
              ST_AHI: begin
                ptr_d[ADDR_W-1:8] = shreg_q[ADDR_W-9:0];
                in_ack_d = 1'b1;
                pull_d   = 1'b1;
              end
              ST_ALO: begin
                ptr_d[7:0] = shreg_q;
                in_ack_d   = 1'b1;
                pull_d     = 1'b1;
              end
              default: begin
                wv_d     = 1'b1;
                wa_d     = ptr_q;
                wd_d     = shreg_q;
                pend_d   = 1'b1;
                ptr_d    = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                in_ack_d = 1'b1;
                pull_d   = 1'b1;
              end
            endcase
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == BYTE_BITS) begin
              pull_d   = 1'b0;
              state_d  = ST_MACK;
              ptr_d    = ptr_q + ADDR_W'(1);
              bitcnt_d = '0;
            end else begin
              tx_d   = {tx_q[6:0], 1'b0};
              pull_d = ~tx_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d  = ST_RDAT;
              tx_d     = rd_data;
              pull_d   = ~rd_data[7];
              bitcnt_d = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      in_ack_q <= 1'b0;
      shreg_q  <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      pull_q   <= 1'b0;
      pend_q   <= 1'b0;
      mack_q   <= 1'b0;
      rw_q     <= 1'b0;
      wv_q     <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      in_ack_q <= in_ack_d;
      shreg_q  <= shreg_d;
      tx_q     <= tx_d;
      ptr_q    <= ptr_d;
      pull_q   <= pull_d;
      pend_q   <= pend_d;
      mack_q   <= mack_d;
      rw_q     <= rw_d;
      wv_q     <= wv_d;
      wa_q     <= wa_d;
      wd_q     <= wd_d;
      commit_q <= commit_d;
    end
  end

  assign sda_pull    = pull_q;
  assign ptr         = ptr_q;
  assign wbyte_valid = wv_q;
  assign wbyte_addr  = wa_q;
  assign wbyte_data  = wd_q;
  assign wcommit     = commit_q;
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int MODEL_AW    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              prog_busy_i,
  output logic              sda_pull_o,
  output logic              wbyte_valid_o,
  output logic [ADDR_W-1:0] wbyte_addr_o,
  output logic [7:0]        wbyte_data_o,
  output logic              wcommit_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  tw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_proto_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .strap       (strap_i),
    .prog_busy   (prog_busy_i),
    .rd_data     (rd_data),
    .sda_pull    (sda_pull_o),
    .ptr         (ptr),
    .wbyte_valid (wbyte_valid_o),
    .wbyte_addr  (wbyte_addr_o),
    .wbyte_data  (wbyte_data_o),
    .wcommit     (wcommit_o)
  );

  tw_array_model #(.ADDR_W(ADDR_W), .MODEL_AW(MODEL_AW)) u_mem (
    .clk   (clk),
    .we    (wbyte_valid_o),
    .waddr (wbyte_addr_o),
    .wdata (wbyte_data_o),
    .raddr (ptr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_pull,
  input logic              scl_lvl,
  input logic              start_det,
  input logic              stop_det,
  input logic              wbyte_valid,
  input logic [ADDR_W-1:0] wbyte_addr,
  input logic              wcommit
);
  logic              have_prev_q;
  logic [ADDR_W-1:0] last_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      last_addr_q <= '0;
    end else if (start_det) begin
      have_prev_q <= 1'b0;
    end else if (wbyte_valid) begin
      have_prev_q <= 1'b1;
      last_addr_q <= wbyte_addr;
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_lvl); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull); // R1

  AST_WBYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_valid |=> !wbyte_valid); // R3

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wbyte_valid && have_prev_q) |->
      (wbyte_addr[ADDR_W-1:PAGE_W] == last_addr_q[ADDR_W-1:PAGE_W]) &&
      (wbyte_addr[PAGE_W-1:0] == last_addr_q[PAGE_W-1:0] + PAGE_W'(1))); // R4

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wcommit |-> $past(stop_det)); // R5
endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_pull    (sda_pull_o),
  .scl_lvl     (scl_lvl),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .wbyte_valid (wbyte_valid_o),
  .wbyte_addr  (wbyte_addr_o),
  .wcommit     (wcommit_o)
);

// File: tb/sim_tw_eeprom_slave.sv
`timescale 1ns/1ps
module sim_tw_eeprom_slave;
  localparam int         HALF  = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

  logic        clk;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic        sda_bus;
  logic        prog_busy;
  logic        sda_pull_o;
  logic        wbyte_valid_o;
  logic [12:0] wbyte_addr_o;
  logic [7:0]  wbyte_data_o;
  logic        wcommit_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [12:0] ev_addr [64];
  logic [7:0]  ev_data [64];
  int          ev_cnt      = 0;
  int          commit_cnt  = 0;
  int          pull_hi_scl = 0;
  int          pull_cycles = 0;
  logic        prev_pull   = 1'b0;

  assign sda_bus = sda_m & ~sda_pull_o;

  tw_eeprom_slave u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_bus),
    .strap_i       (STRAP),
    .prog_busy_i   (prog_busy),
    .sda_pull_o    (sda_pull_o),
    .wbyte_valid_o (wbyte_valid_o),
    .wbyte_addr_o  (wbyte_addr_o),
    .wbyte_data_o  (wbyte_data_o),
    .wcommit_o     (wcommit_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wbyte_valid_o) begin
        if (ev_cnt < 64) begin
          ev_addr[ev_cnt] = wbyte_addr_o;
          ev_data[ev_cnt] = wbyte_data_o;
        end
        ev_cnt++;
      end
      if (wcommit_o) commit_cnt++;
      if (sda_pull_o !== prev_pull && scl_m) pull_hi_scl++;
      if (sda_pull_o) pull_cycles++;
    end
    prev_pull = sda_pull_o;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF / 2);
    acked = ~sda_bus;
    tick(HALF / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic sendc(input logic [7:0] b, input logic exp_ack, input string req);
    logic ak;
    send_byte(b, ak);
    check(ak === exp_ack, req, {31'd0, ak}, {31'd0, exp_ack});
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      scl_m = 1'b1; tick(HALF / 2);
      b[i] = sda_bus;
      tick(HALF / 2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = ~give_ack; tick(HALF);
    scl_m = 1'b1; tick(HALF / 2);
    if (!give_ack) check(sda_pull_o === 1'b0, "R10 released in master ack", {31'd0, sda_pull_o}, 0);
    tick(HALF / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic getc(input logic give_ack, input logic [7:0] exp, input string req);
    logic [7:0] d;
    get_byte(give_ack, d);
    check(d === exp, req, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bus_start();
    sendc(SEL_W, 1'b1, req);
    sendc(hi, 1'b1, req);
    sendc(lo, 1'b1, req);
  endtask

  task automatic t_reset();
    check(sda_pull_o === 1'b0, "R11 sda released", {31'd0, sda_pull_o}, 0);
    check(wbyte_valid_o === 1'b0, "R11 no strobe", {31'd0, wbyte_valid_o}, 0);
    check(wcommit_o === 1'b0, "R11 no commit", {31'd0, wcommit_o}, 0);
  endtask

  task automatic t_write_basic();
    int e0 = ev_cnt;
    int c0 = commit_cnt;
    set_addr(8'hF2, 8'h34, "R3 select/address ack");
    sendc(8'h11, 1'b1, "R3 data ack");
    sendc(8'h22, 1'b1, "R3 data ack");
    sendc(8'h33, 1'b1, "R3 data ack");
    bus_stop(); tick(5);
    check(ev_cnt - e0 == 3, "R3 strobe count", ev_cnt - e0, 3);
    for (int k = 0; k < 3; k++) begin
      check(ev_addr[e0 + k] === 13'h1234 + 13'(k), "R3 strobe address", {19'd0, ev_addr[e0 + k]}, 32'h1234 + k);
      check(ev_data[e0 + k] === 8'h11 * 8'(k + 1), "R3 strobe data", {24'd0, ev_data[e0 + k]}, 32'h11 * (k + 1));
    end
    check(commit_cnt - c0 == 1, "R5 one commit", commit_cnt - c0, 1);
  endtask

  task automatic t_random_and_current();
    set_addr(8'h12, 8'h35, "R6 dummy write ack");
    bus_start();
    sendc(SEL_R, 1'b1, "R6 read select ack");
    getc(1'b0, 8'h22, "R6 random read data");
    bus_stop();
    bus_start();
    sendc(SEL_R, 1'b1, "R8 read select ack");
    getc(1'b0, 8'h33, "R8 current address data");
    bus_stop();
  endtask

  task automatic t_sequential();
    set_addr(8'h12, 8'h34, "R7 address ack");
    bus_start();
    sendc(SEL_R, 1'b1, "R7 read select ack");
    getc(1'b1, 8'h11, "R7 seq byte 0");
    getc(1'b1, 8'h22, "R7 seq byte 1");
    getc(1'b0, 8'h33, "R7 seq byte 2");
    bus_stop();
  endtask

  task automatic t_array_wrap();
    set_addr(8'h1F, 8'hFF, "R7 wrap setup");
    sendc(8'hA5, 1'b1, "R7 wrap setup data");
    bus_stop();
    set_addr(8'h00, 8'h00, "R7 wrap setup");
    sendc(8'h5A, 1'b1, "R7 wrap setup data");
    bus_stop();
    set_addr(8'h1F, 8'hFF, "R7 wrap address");
    bus_start();
    sendc(SEL_R, 1'b1, "R7 wrap read select");
    getc(1'b1, 8'hA5, "R7 byte at 8191");
    getc(1'b0, 8'h5A, "R7 byte after wrap to 0");
    bus_stop();
  endtask

  task automatic t_page_wrap();
    int e0 = ev_cnt;
    set_addr(8'h1F, 8'hFE, "R4 address ack");
    sendc(8'h01, 1'b1, "R4 data ack");
    sendc(8'h02, 1'b1, "R4 data ack");
    sendc(8'h03, 1'b1, "R4 data ack");
    bus_stop(); tick(5);
    check(ev_addr[e0]     === 13'h1FFE, "R4 page addr 0", {19'd0, ev_addr[e0]}, 32'h1FFE);
    check(ev_addr[e0 + 1] === 13'h1FFF, "R4 page addr 1", {19'd0, ev_addr[e0 + 1]}, 32'h1FFF);
    check(ev_addr[e0 + 2] === 13'h1FE0, "R4 page wrap addr", {19'd0, ev_addr[e0 + 2]}, 32'h1FE0);
  endtask

  task automatic t_bad_select();
    int p0 = pull_cycles;
    int c0 = commit_cnt;
    bus_start();
    sendc({4'b1010, 3'b011, 1'b0}, 1'b0, "R2 strap mismatch no ack");
    sendc(8'h00, 1'b0, "R2 ignored after mismatch");
    sendc(SEL_W, 1'b0, "R2 ignored until start");
    bus_stop();
    bus_start();
    sendc({4'b1011, STRAP, 1'b0}, 1'b0, "R2 code mismatch no ack");
    bus_stop(); tick(5);
    check(pull_cycles == p0, "R2 sda never pulled", pull_cycles - p0, 0);
    check(commit_cnt == c0, "R2 no commit", commit_cnt - c0, 0);
    bus_start();
    sendc(SEL_W, 1'b1, "R2 matching select ack");
    bus_stop();
  endtask

  task automatic t_busy();
    prog_busy = 1'b1;
    bus_start();
    sendc(SEL_W, 1'b0, "R9 busy select no ack");
    bus_stop();
    prog_busy = 1'b0;
    bus_start();
    sendc(SEL_W, 1'b1, "R9 select ack after busy");
    bus_stop();
  endtask

  task automatic t_no_commit();
    int c0 = commit_cnt;
    set_addr(8'h01, 8'h00, "R5 address only");
    bus_stop(); tick(5);
    check(commit_cnt == c0, "R5 no commit without data", commit_cnt - c0, 0);
    set_addr(8'h01, 8'h00, "R5 aborted write");
    sendc(8'h77, 1'b1, "R5 aborted write data");
    bus_start();
    bus_stop(); tick(5);
    check(commit_cnt == c0, "R5 no commit after start abort", commit_cnt - c0, 0);
  endtask

  task automatic t_abort_midbyte();
    set_addr(8'h12, 8'h34, "R1 address ack");
    bus_start();
    for (int i = 7; i >= 4; i--) put_bit(SEL_W[i]);
    bus_start();
    sendc(SEL_R, 1'b1, "R1 select after abort ack");
    getc(1'b0, 8'h11, "R1 data after abort");
    bus_stop(); tick(5);
    check(sda_pull_o === 1'b0, "R1 released after stop", {31'd0, sda_pull_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    prog_busy = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_basic();
    t_random_and_current();
    t_sequential();
    t_array_wrap();
    t_page_wrap();
    t_bad_select();
    t_busy();
    t_no_commit();
    t_abort_midbyte();
    check(pull_hi_scl == 0, "R10 pull changed with SCL high", pull_hi_scl, 0);
    finish_up();
  end
endmodule